// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. It has signed and unsigned modes. The quotient is rounded toward zero. The remainder takes the sign of the dividend. A one-cycle `start` strobe captures the operands together with the `long_mode` and `signed_mode` selectors. The block then steps through a non-restoring shift and add/subtract datapath, one iteration per divisor bit. For that reason the 32/16 and 16/16 operations take the same number of cycles.

The controller is a state machine with six states:

- `ST_IDLE` waits for a request.
- `ST_PREP` turns the captured operands into magnitudes and pre-checks for a quotient that is too wide.
- `ST_ITER` runs one quotient bit per cycle for 16 cycles.
- `ST_FIX` adds the divisor back once if the partial remainder ended negative.
- `ST_FIN` applies the signs, detects divide-by-zero and overflow, and registers the results.
- `ST_DONE` raises `done` for one cycle.

The transitions are:

- `start` moves `ST_IDLE` to `ST_PREP`.
- A non-stalled cycle moves `ST_PREP` to `ST_ITER`.
- A non-stalled last iteration moves `ST_ITER` to `ST_FIX`.
- A non-stalled cycle moves `ST_FIX` to `ST_FIN`, and `ST_FIN` to `ST_DONE`.
- From `ST_DONE`, `start` moves to `ST_PREP`, otherwise the block returns to `ST_IDLE`.
- While `stall` is high in any busy state, the state and every iteration register hold.

The results stay on the output ports until the next `done`, so the surrounding pipeline can write them back whenever it is ready.

Top module: `iter_divider`

## Requirements
- R1: With `long_mode`=1 the full 32-bit `dividend` is divided. With `long_mode`=0 only `dividend[15:0]` is used: it is sign-extended when `signed_mode`=1 and zero-extended otherwise, and bits 31:16 have no effect. `signed_mode`=1 treats both operands as two's complement. The quotient is truncated toward zero.
- R2: When neither flag is raised, `remainder` has the sign of the dividend (or is zero), its magnitude is below the divisor's, and dividend = quotient*divisor + remainder.
- R3: A request accepted at a clock edge raises `done` exactly 19 non-stalled cycles later, for one cycle only. `busy` is high in every cycle between the two and is never high together with `done`. After reset, `busy`, `done`, both flags and both results are zero.
- R4: While `busy` is high, each cycle with `stall`=1 freezes the divider and delays `done` by exactly one cycle. `stall` has no effect while the block is not busy.
- R5: A `start` while `busy` is high is ignored: it neither restarts the operation nor alters its result. A `start` in the `done` cycle is accepted.
- R6: A zero divisor raises `div_zero` at `done`, keeps `q_ovf` low, and returns quotient 0xFFFF and remainder `dividend[15:0]`.
- R7: With a non-zero divisor, a true quotient outside the 16-bit range raises `q_ovf` at `done`, and returns quotient 0xFFFF and remainder `dividend[15:0]`. The signed range is -32768..32767 and the unsigned range is 0..65535. A 16/16 unsigned divide never overflows.
- R8: `quotient`, `remainder`, `div_zero` and `q_ovf` change only in a `done` cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| stall | input | 1 | Freezes the divider between cycles while busy |
| long_mode | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| signed_mode | input | 1 | 1: two's complement operands |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| div_zero | output | 1 | Divisor was zero |
| q_ovf | output | 1 | Quotient did not fit in 16 bits |

## Verification
The assertions assume that `start` and `stall` are clean, synchronous levels that change only away from the clock edge. They also assume that the mode and operand inputs matter only in the cycle where `start` is accepted. The stimulus drives every input on the falling edge. It changes operands only together with a `start` pulse, except for deliberate ignored-`start` attempts while busy. It drives `stall` both during operations and while idle. The bench model keeps its own count of remaining cycles and its own held results, and compares every output on every clock.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ITER,
        ST_FIX,
        ST_FIN,
        ST_DONE
    } div_state_e;

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: extension, magnitude conversion and wide-quotient pre-check.
module idiv_prep #(
    parameter int QW = 16
) (
    input  logic [2*QW-1:0] dvd_raw,
    input  logic [QW-1:0]   dvs_raw,
    input  logic            long_mode,
    input  logic            signed_mode,
    output logic [2*QW-1:0] dvd_mag,
    output logic [QW-1:0]   dvs_mag,
    output logic            dvd_neg,
    output logic            dvs_neg,
    output logic            hi_ovf,
    output logic            dvs_zero
);
    localparam int DW = 2 * QW;

    logic [DW-1:0] dvd_ext;

    always_comb begin
        if (long_mode) begin
            dvd_ext = dvd_raw;
        end else if (signed_mode) begin
            dvd_ext = {{QW{dvd_raw[QW-1]}}, dvd_raw[QW-1:0]};
        end else begin
            dvd_ext = {{QW{1'b0}}, dvd_raw[QW-1:0]};
        end
        dvd_neg  = signed_mode & dvd_ext[DW-1];
        dvs_neg  = signed_mode & dvs_raw[QW-1];
        dvd_mag  = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
        dvs_mag  = dvs_neg ? (~dvs_raw + 1'b1) : dvs_raw;
        dvs_zero = (dvs_raw == '0);
        // quotient magnitude needs more than QW bits when the upper half is not below the divisor
        hi_ovf   = (dvd_mag[DW-1:QW] >= dvs_mag);
    end
endmodule

// File: rtl/idiv_step.sv
// One non-restoring iteration: shift in the next dividend bit, add or subtract the divisor.
module idiv_step #(
    parameter int QW = 16
) (
    input  logic [QW:0]   p_in,
    input  logic [QW-1:0] q_in,
    input  logic [QW-1:0] d_in,
    output logic [QW:0]   p_out,
    output logic [QW-1:0] q_out
);
    localparam int SW = QW + 2;

    logic [SW-1:0] shifted;
    logic [SW-1:0] dvs_x;
    logic [SW-1:0] sum;

    always_comb begin
        shifted = {p_in, q_in[QW-1]};
        dvs_x   = {2'b00, d_in};
        sum     = p_in[QW] ? (shifted + dvs_x) : (shifted - dvs_x);
        p_out   = sum[QW:0];
        q_out   = {q_in[QW-2:0], ~sum[QW]};
    end
endmodule

// File: rtl/idiv_post.sv
// Result formation: sign application, error precedence and forced values.
module idiv_post #(
    parameter int QW = 16
) (
    input  logic [QW-1:0] q_mag,
    input  logic [QW-1:0] r_mag,
    input  logic          dvd_neg,
    input  logic          dvs_neg,
    input  logic          signed_mode,
    input  logic          hi_ovf,
    input  logic          dvs_zero,
    input  logic [QW-1:0] lo_word,
    output logic [QW-1:0] quo,
    output logic [QW-1:0] rem,
    output logic          dz,
    output logic          ovf
);
    localparam logic [QW-1:0] HALF = QW'(1) << (QW - 1);

    logic diff_sign;
    logic sgn_ovf;

    always_comb begin
        diff_sign = dvd_neg ^ dvs_neg;
        sgn_ovf   = signed_mode & (diff_sign ? (q_mag > HALF) : q_mag[QW-1]);
        dz        = dvs_zero;
        ovf       = ~dvs_zero & (hi_ovf | sgn_ovf);
        if (dz || ovf) begin
            quo = '1;
            rem = lo_word;
        end else begin
            quo = diff_sign ? (~q_mag + 1'b1) : q_mag;
            rem = dvd_neg ? (~r_mag + 1'b1) : r_mag;
        end
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import idiv_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stall,
    input  logic              long_mode,
    input  logic              signed_mode,
    input  logic [2*QW-1:0]   dividend,
    input  logic [QW-1:0]     divisor,
    output logic              busy,
    output logic              done,
    output logic [QW-1:0]     quotient,
    output logic [QW-1:0]     remainder,
    output logic              div_zero,
    output logic              q_ovf
);
    localparam int DW = 2 * QW;
    localparam int PW = QW + 1;
    localparam int CW = $clog2(QW);
    localparam logic [CW-1:0] LAST_IT = CW'(QW - 1);

    div_state_e state_q, state_d;

    // captured request
    logic [DW-1:0] dvd_cap;
    logic [QW-1:0] dvs_cap;
    logic          long_cap, sgn_cap;

    // iteration state
    logic [PW-1:0] p_q;
    logic [QW-1:0] q_q;
    logic [QW-1:0] d_q;
    logic [CW-1:0] cnt_q;
    logic          dvd_neg_q, dvs_neg_q, hi_ovf_q, zero_q;

    // combinational helpers
    logic [DW-1:0] pre_dvd_mag;
    logic [QW-1:0] pre_dvs_mag;
    logic          pre_dvd_neg, pre_dvs_neg, pre_hi_ovf, pre_zero;
    logic [PW-1:0] step_p;
    logic [QW-1:0] step_q;
    logic [PW-1:0] p_fixed;
    logic [QW-1:0] post_quo, post_rem;
    logic          post_dz, post_ovf;
    logic          accept;

    idiv_prep #(.QW(QW)) u_prep (
        .dvd_raw    (dvd_cap),
        .dvs_raw    (dvs_cap),
        .long_mode  (long_cap),
        .signed_mode(sgn_cap),
        .dvd_mag    (pre_dvd_mag),
        .dvs_mag    (pre_dvs_mag),
        .dvd_neg    (pre_dvd_neg),
        .dvs_neg    (pre_dvs_neg),
        .hi_ovf     (pre_hi_ovf),
        .dvs_zero   (pre_zero)
    );

    idiv_step #(.QW(QW)) u_step (
        .p_in (p_q),
        .q_in (q_q),
        .d_in (d_q),
        .p_out(step_p),
        .q_out(step_q)
    );

    idiv_post #(.QW(QW)) u_post (
        .q_mag      (q_q),
        .r_mag      (p_q[QW-1:0]),
        .dvd_neg    (dvd_neg_q),
        .dvs_neg    (dvs_neg_q),
        .signed_mode(sgn_cap),
        .hi_ovf     (hi_ovf_q),
        .dvs_zero   (zero_q),
        .lo_word    (dvd_cap[QW-1:0]),
        .quo        (post_quo),
        .rem        (post_rem),
        .dz         (post_dz),
        .ovf        (post_ovf)
    );

    assign accept  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign p_fixed = p_q[QW] ? (p_q + {1'b0, d_q}) : p_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PREP;
            ST_PREP: if (!stall) state_d = ST_ITER;
            ST_ITER: if (!stall && (cnt_q == LAST_IT)) state_d = ST_FIX;
            ST_FIX:  if (!stall) state_d = ST_FIN;
            ST_FIN:  if (!stall) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_PREP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_PREP, ST_ITER, ST_FIX, ST_FIN: busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_cap  <= '0;
            dvs_cap  <= '0;
            long_cap <= 1'b0;
            sgn_cap  <= 1'b0;
        end else if (accept) begin
            dvd_cap  <= dividend;
            dvs_cap  <= divisor;
            long_cap <= long_mode;
            sgn_cap  <= signed_mode;
        end
    end

    // iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q       <= '0;
            q_q       <= '0;
            d_q       <= '0;
            cnt_q     <= '0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            hi_ovf_q  <= 1'b0;
            zero_q    <= 1'b0;
        end else if (!stall) begin
            if (state_q == ST_PREP) begin
                p_q       <= {1'b0, pre_dvd_mag[DW-1:QW]};
                q_q       <= pre_dvd_mag[QW-1:0];
                d_q       <= pre_dvs_mag;
                cnt_q     <= '0;
                dvd_neg_q <= pre_dvd_neg;
                dvs_neg_q <= pre_dvs_neg;
                hi_ovf_q  <= pre_hi_ovf;
                zero_q    <= pre_zero;
            end else if (state_q == ST_ITER) begin
                p_q   <= step_p;
                q_q   <= step_q;
                cnt_q <= cnt_q + 1'b1;
            end else if (state_q == ST_FIX) begin
                p_q <= p_fixed;
            end
        end
    end

    // result registers, loaded once per operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            q_ovf     <= 1'b0;
        end else if ((state_q == ST_FIN) && !stall) begin
            quotient  <= post_quo;
            remainder <= post_rem;
            div_zero  <= post_dz;
            q_ovf     <= post_ovf;
        end
    end
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk
    import idiv_pkg::*;
#(
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          stall,
    input logic          long_mode,
    input logic          signed_mode,
    input logic [QW-1:0] divisor,
    input logic          busy,
    input logic          done,
    input logic [QW-1:0] quotient,
    input logic [QW-1:0] remainder,
    input logic          div_zero,
    input logic          q_ovf,
    input div_state_e    state_q
);
    localparam logic [7:0] LAT = 8'(QW + 3);

    logic [7:0] run_cnt;
    logic       zero_exp, long_exp, sgn_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            zero_exp <= 1'b0;
            long_exp <= 1'b0;
            sgn_exp  <= 1'b0;
        end else if (start && !busy) begin
            run_cnt  <= '0;
            zero_exp <= (divisor == '0);
            long_exp <= long_mode;
            sgn_exp  <= signed_mode;
        end else if (busy && !stall) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == LAT));
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> (busy && $stable(state_q)));
    assert_busy_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_zero == zero_exp));
    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(div_zero && q_ovf));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !long_exp && !sgn_exp) |-> !q_ovf);
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero) && $stable(q_ovf)));
endmodule

bind iter_divider iter_divider_chk #(.QW(QW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stall      (stall),
    .long_mode  (long_mode),
    .signed_mode(signed_mode),
    .divisor    (divisor),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .remainder  (remainder),
    .div_zero   (div_zero),
    .q_ovf      (q_ovf),
    .state_q    (state_q)
);

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stall = 1'b0;
    logic        long_mode = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero, q_ovf;
    logic [15:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R3";

    // reference model state
    int          m_left = 0;
    logic        m_done = 1'b0;
    logic [15:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
    logic        m_z = 1'b0, m_o = 1'b0, p_z = 1'b0, p_o = 1'b0;

    always #2 clk = ~clk;

    iter_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
        .long_mode(long_mode), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .div_zero(div_zero), .q_ovf(q_ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void calc(input logic lm, input logic sg, input logic [31:0] a,
                                 input logic [15:0] b, output logic [15:0] eq,
                                 output logic [15:0] er, output logic ez, output logic eo);
        longint av, bv, qv, rv;
        if (lm) av = sg ? longint'($signed(a)) : longint'(a);
        else    av = sg ? longint'($signed(a[15:0])) : longint'(a[15:0]);
        bv = sg ? longint'($signed(b)) : longint'(b);
        ez = 1'b0;
        eo = 1'b0;
        eq = 16'hFFFF;
        er = a[15:0];
        if (bv == 0) begin
            ez = 1'b1;
        end else begin
            qv = av / bv;
            rv = av % bv;
            if (sg) eo = (qv > 32767) || (qv < -32768);
            else    eo = (qv > 65535);
            if (!eo) begin
                eq = qv[15:0];
                er = rv[15:0];
            end
        end
    endfunction

    // cycle model: request accepted when idle, done 19 unstalled cycles later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_left <= 0; m_done <= 1'b0;
            m_q <= '0; m_r <= '0; m_z <= 1'b0; m_o <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (m_left > 0) begin
                if (!stall) begin
                    if (m_left == 1) begin
                        m_done <= 1'b1;
                        m_q <= p_q; m_r <= p_r; m_z <= p_z; m_o <= p_o;
                    end
                    m_left <= m_left - 1;
                end
            end else if (start) begin
                logic [15:0] tq, tr;
                logic tz, to;
                calc(long_mode, signed_mode, dividend, divisor, tq, tr, tz, to);
                p_q <= tq; p_r <= tr; p_z <= tz; p_o <= to;
                m_left <= 19;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_left > 0), "R3", "busy", longint'(busy), longint'(m_left > 0));
            chk(done == m_done, cur_req, "done", longint'(done), longint'(m_done));
            chk(quotient == m_q, cur_req, "quotient", longint'(quotient), longint'(m_q));
            chk(remainder == m_r, cur_req, "remainder", longint'(remainder), longint'(m_r));
            chk(div_zero == m_z, "R6", "div_zero", longint'(div_zero), longint'(m_z));
            chk(q_ovf == m_o, "R7", "q_ovf", longint'(q_ovf), longint'(m_o));
        end
    end

    // issue one operation from a falling edge, stalling every n-th cycle when n > 0
    task automatic run_div(input string req, input logic lm, input logic sg,
                           input logic [31:0] a, input logic [15:0] b, input int n);
        int waited;
        cur_req = req;
        long_mode = lm; signed_mode = sg; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 1;
        for (int i = 1; i < 80; i++) begin
            stall = (n > 0) && (i % n == 0);
            @(negedge clk);
            waited++;
            if (m_done) break;
        end
        stall = 1'b0;
        chk(done == 1'b1, req, "done reached", longint'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R3", "reset busy/done", longint'({busy, done}), 0);
        chk(quotient == 0 && remainder == 0, "R3", "reset results",
            longint'({quotient, remainder}), 0);
        chk(div_zero == 0 && q_ovf == 0, "R3", "reset flags", longint'({div_zero, q_ovf}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: unsigned and signed, both widths
        run_div("R1", 1, 0, 32'd100000, 16'd7, 0);
        chk(quotient == 16'd14285 && remainder == 16'd5, "R1", "100000/7",
            longint'({quotient, remainder}), longint'({16'd14285, 16'd5}));
        run_div("R1", 1, 0, 32'h00FF_FFFF, 16'h0100, 0);
        run_div("R2", 1, 1, -32'sd100000, 16'd7, 0);
        chk(remainder == 16'hFFFB, "R2", "remainder sign follows dividend",
            longint'(remainder), longint'(16'hFFFB));
        run_div("R2", 1, 1, 32'd100000, -16'sd300, 0);
        run_div("R2", 1, 1, -32'sd70000, -16'sd3, 0);
        run_div("R1", 0, 0, 32'hDEAD_0064, 16'd10, 0);
        chk(quotient == 16'd10 && remainder == 0, "R1", "upper bits ignored in short mode",
            longint'({quotient, remainder}), longint'({16'd10, 16'd0}));
        run_div("R1", 0, 0, 32'h0000_FFFF, 16'd1, 0);
        run_div("R1", 0, 1, 32'h1234_FFF9, 16'd2, 0);
        chk(quotient == 16'hFFFD && remainder == 16'hFFFF, "R1", "-7/2 short signed",
            longint'({quotient, remainder}), longint'({16'hFFFD, 16'hFFFF}));
        run_div("R2", 1, 0, 32'hFFFE_FFFF, 16'hFFFF, 0);

        // R6: zero divisor
        run_div("R6", 1, 1, 32'h8765_4321, 16'd0, 0);
        chk(div_zero && !q_ovf && quotient == 16'hFFFF && remainder == 16'h4321, "R6",
            "zero divisor", longint'({div_zero, q_ovf, quotient}), longint'({2'b10, 16'hFFFF}));
        run_div("R6", 0, 0, 32'h0000_0005, 16'd0, 0);

        // R7: quotient range edges
        run_div("R7", 1, 0, 32'h0001_0000, 16'd1, 0);
        chk(q_ovf == 1'b1, "R7", "unsigned wide quotient", longint'(q_ovf), 1);
        run_div("R7", 0, 1, 32'h0000_8000, 16'hFFFF, 0);
        chk(q_ovf == 1'b1, "R7", "-32768/-1", longint'(q_ovf), 1);
        run_div("R7", 1, 1, 32'h0000_8000, 16'd1, 0);
        run_div("R7", 1, 1, 32'hFFFF_8000, 16'd1, 0);
        chk(q_ovf == 1'b0 && quotient == 16'h8000, "R7", "-32768 fits",
            longint'({q_ovf, quotient}), longint'({1'b0, 16'h8000}));
        run_div("R7", 1, 1, 32'h0001_0000, 16'hFFFE, 0);

        // R4: stalls while busy, and while idle
        stall = 1'b1;
        repeat (3) @(negedge clk);
        stall = 1'b0;
        run_div("R4", 1, 1, -32'sd123456, 16'd321, 2);
        run_div("R4", 1, 0, 32'd999999, 16'd1000, 5);

        // R5: start while busy ignored, start in done cycle accepted
        cur_req = "R5";
        long_mode = 1; signed_mode = 0; dividend = 32'd5000; divisor = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dividend = 32'd77; divisor = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (m_done) break;
            @(negedge clk);
        end
        chk(done && quotient == 16'd1666 && remainder == 16'd2, "R5", "ignored start",
            longint'({quotient, remainder}), longint'({16'd1666, 16'd2}));
        run_div("R5", 1, 1, -32'sd45, 16'd4, 0);
        run_div("R8", 0, 1, 32'd300, -16'sd7, 0);
        repeat (10) @(negedge clk);
        chk(quotient == 16'hFFD6 && remainder == 16'd6, "R8", "results held",
            longint'({quotient, remainder}), longint'({16'hFFD6, 16'd6}));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule